// File: doc/BRIEF.md
# FSK Deviation and Bank Selector

This block picks which of two stored frequency configurations, bank F1 or bank F2, feeds the fractional-N divider. It also adds a signed frequency-shift-keying deviation to that bank's fractional numerator. The active bank follows either a configuration bit or a transmit/receive control pin. The pin path has a programmable polarity and a two-flop synchronizer. The block drives the enables for the transmit and receive output ports, and it can turn both ports on together to act as a fanout.

Each bank keeps eight 16-bit deviation words. The deviation word comes from one of three sources. In pin mode, symbol inputs pick the word and are trimmed to the number of bits the FSK level needs. In register mode, a select field picks the word. In fast register mode, one dedicated word is used. The deviation is added only when the active bank has FSK enabled and a zero denominator. The sum is registered, so the numerator seen by the divider changes only on a clock edge.

Top module: `fsk_bank_sel`

## Requirements
- R1: While reset is asserted and directly after it, numOut, bankOut, txEn and rxEn are all 0.
- R2: With pin switching inactive, bankSelReg=0 selects F1 and bankSelReg=1 selects F2. bankOut shows the bank (0=F1, 1=F2), and numOut carries that bank's base numerator. When fanout is off, txEn=1 for F1 and rxEn=1 for F2. All of these appear one clock after the inputs.
- R3: The pin controls the bank only when trPinMode and trPinAllow are both 1. If either is 0, trCtl has no effect and bankSelReg decides.
- R4: In pin mode with trPolarity=0, trCtl high selects F1/transmit and trCtl low selects F2/receive. trPolarity=1 swaps the two pin levels. A trCtl change reaches the outputs on the third clock edge and not earlier.
- R5: fanoutEn=1 drives txEn=1 and rxEn=1 together, whatever the bank.
- R6: fskLevel=0 blocks the deviation in pin mode (fskMode=0) and in register mode (fskMode=1).
- R7: In pin mode, fskLevel 1, 2 and 3 use 1, 2 and 3 low symIn bits as the table index. Higher index bits are treated as 0.
- R8: In register mode, devSel chooses the table entry.
- R9: In fast mode (fskMode=2), fastDev is the deviation for both banks, and fskLevel does not matter.
- R10: The deviation is a two's-complement word, sign-extended and added to the base numerator modulo 2^24.
- R11: No deviation is added when the active bank's denominator is nonzero, when its fskEn bit is 0, or when fskMode=3.
- R12: Table entry k of a bank is bits [16k+15:16k] of that bank's devTab vector. The table used is always the one of the active bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bankSelReg | input | 1 | Register bank select, 0=F1, 1=F2 |
| trPinMode | input | 1 | Requests bank switching by pin |
| trPinAllow | input | 1 | Second bit needed for pin switching |
| trPolarity | input | 1 | Inverts the meaning of trCtl |
| fanoutEn | input | 1 | Turns both output ports on |
| trCtl | input | 1 | Asynchronous transmit/receive control pin |
| fskMode | input | 2 | 0 pin, 1 register, 2 fast, 3 off |
| fskLevel | input | 2 | 0 off, 1/2/3 for 2/4/8 levels |
| devSel | input | 3 | Register-mode table index |
| symIn | input | 3 | Pin-mode symbol bits |
| fastDev | input | 16 | Fast-mode deviation word |
| fskEnF1 | input | 1 | FSK enable of bank F1 |
| fskEnF2 | input | 1 | FSK enable of bank F2 |
| baseNumF1 | input | 24 | Base numerator of F1 |
| baseNumF2 | input | 24 | Base numerator of F2 |
| denF1 | input | 24 | Denominator of F1 |
| denF2 | input | 24 | Denominator of F2 |
| devTabF1 | input | 128 | Eight deviation words of F1 |
| devTabF2 | input | 128 | Eight deviation words of F2 |
| numOut | output | 24 | Registered numerator with deviation |
| bankOut | output | 1 | Registered active bank |
| txEn | output | 1 | Transmit port enable |
| rxEn | output | 1 | Receive port enable |

## Verification
A change on a configuration, select or symbol input shows up on the outputs at the first rising edge after it. A change on trCtl passes two synchronizer stages and the output register, so it is due at the third edge. The driver stamps each expected item with the cycle in which it is due: the current cycle count plus one, or plus three for a pin toggle. The monitor compares the outputs at the falling edge of that cycle. For one pin toggle, an extra item expects the old bank at the second edge, which catches a synchronizer with a missing stage.

// File: rtl/fsk_bank_pkg.sv
package fsk_bank_pkg;

  typedef enum logic [1:0] {
    FSK_PIN  = 2'd0,
    FSK_REG  = 2'd1,
    FSK_FAST = 2'd2,
    FSK_OFF  = 2'd3
  } fskMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic bankF2;
    logic applyDev;
    logic useFast;
    logic txOn;
    logic rxOn;
  } bankCtl_t;

endpackage

// File: rtl/fsk_bank_ctrl.sv
module fsk_bank_ctrl
  import fsk_bank_pkg::*;
#(
  parameter int NUM_W     = 24,
  parameter int DEV_DEPTH = 8,
  localparam int IDX_W    = $clog2(DEV_DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bankSelReg,
  input  logic             trPinMode,
  input  logic             trPinAllow,
  input  logic             trPolarity,
  input  logic             fanoutEn,
  input  logic             trCtl,
  input  logic [1:0]       fskMode,
  input  logic [1:0]       fskLevel,
  input  logic [IDX_W-1:0] devSel,
  input  logic [IDX_W-1:0] symIn,
  input  logic             fskEnF1,
  input  logic             fskEnF2,
  input  logic [NUM_W-1:0] denF1,
  input  logic [NUM_W-1:0] denF2,
  output bankCtl_t         ctl,
  output logic [IDX_W-1:0] devIndex
);

  logic [1:0]       trSync;
  logic             pinActive;
  logic             txSide;
  logic             bankF2;
  logic             fskEnAct;
  logic             denZero;
  logic [IDX_W-1:0] lvlMask;

  // Two-stage synchronizer for the asynchronous pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trSync <= '0;
    else       trSync <= {trSync[0], trCtl};
  end

  assign pinActive = trPinMode & trPinAllow;
  assign txSide    = trSync[1] ^ trPolarity;
  assign bankF2    = pinActive ? ~txSide : bankSelReg;
  assign fskEnAct  = bankF2 ? fskEnF2 : fskEnF1;
  assign denZero   = bankF2 ? (denF2 == '0) : (denF1 == '0);

  // Level L keeps the L low symbol bits
  for (genvar i = 0; i < IDX_W; i++) begin : g_mask
    assign lvlMask[i] = (int'(fskLevel) > i);
  end

  always_comb begin
    ctl.bankF2   = bankF2;
    ctl.txOn     = fanoutEn | ~bankF2;
    ctl.rxOn     = fanoutEn | bankF2;
    ctl.applyDev = 1'b0;
    ctl.useFast  = 1'b0;
    devIndex     = '0;
    unique case (fskMode_e'(fskMode))
      FSK_PIN: begin
        ctl.applyDev = fskEnAct & denZero & (fskLevel != 2'd0);
        devIndex     = symIn & lvlMask;
      end
      FSK_REG: begin
        ctl.applyDev = fskEnAct & denZero & (fskLevel != 2'd0);
        devIndex     = devSel;
      end
      FSK_FAST: begin
        ctl.applyDev = fskEnAct & denZero;
        ctl.useFast  = 1'b1;
      end
      default: ;
    endcase
  end

  assert_level_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fskLevel == 2'd0 && fskMode[1] == 1'b0) |-> !ctl.applyDev);

  assert_index_mask_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fskMode == 2'd0 && fskLevel == 2'd1) |-> (devIndex[IDX_W-1:1] == '0));

  assert_den_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    (denF1 != '0 && denF2 != '0) |-> !ctl.applyDev);

endmodule

// File: rtl/fsk_bank_dp.sv
module fsk_bank_dp
  import fsk_bank_pkg::*;
#(
  parameter int NUM_W     = 24,
  parameter int DEV_W     = 16,
  parameter int DEV_DEPTH = 8,
  localparam int IDX_W    = $clog2(DEV_DEPTH),
  localparam int TAB_W    = DEV_W * DEV_DEPTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  bankCtl_t         ctl,
  input  logic [IDX_W-1:0] devIndex,
  input  logic [DEV_W-1:0] fastDev,
  input  logic [NUM_W-1:0] baseNumF1,
  input  logic [NUM_W-1:0] baseNumF2,
  input  logic [TAB_W-1:0] devTabF1,
  input  logic [TAB_W-1:0] devTabF2,
  output logic [NUM_W-1:0] numOut,
  output logic             bankOut,
  output logic             txEn,
  output logic             rxEn
);

  logic [DEV_W-1:0] devF1 [DEV_DEPTH];
  logic [DEV_W-1:0] devF2 [DEV_DEPTH];
  logic [DEV_W-1:0] devPick;
  logic [NUM_W-1:0] devExt;
  logic [NUM_W-1:0] baseAct;
  logic [NUM_W-1:0] numNext;
  logic             armed;

  for (genvar k = 0; k < DEV_DEPTH; k++) begin : g_unpack
    assign devF1[k] = devTabF1[k*DEV_W +: DEV_W];
    assign devF2[k] = devTabF2[k*DEV_W +: DEV_W];
  end

  always_comb begin
    if (ctl.useFast)     devPick = fastDev;
    else if (ctl.bankF2) devPick = devF2[devIndex];
    else                 devPick = devF1[devIndex];
  end

  assign devExt  = {{(NUM_W-DEV_W){devPick[DEV_W-1]}}, devPick};
  assign baseAct = ctl.bankF2 ? baseNumF2 : baseNumF1;
  assign numNext = baseAct + (ctl.applyDev ? devExt : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      numOut  <= '0;
      bankOut <= 1'b0;
      txEn    <= 1'b0;
      rxEn    <= 1'b0;
      armed   <= 1'b0;
    end else begin
      numOut  <= numNext;
      bankOut <= ctl.bankF2;
      txEn    <= ctl.txOn;
      rxEn    <= ctl.rxOn;
      armed   <= 1'b1;
    end
  end

  assert_port_on_R5: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (txEn || rxEn));

  assert_port_follows_bank_R2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !(txEn && rxEn)) |-> (txEn == !bankOut));

  assert_passthru_R11: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(ctl.applyDev)) |->
      (numOut == $past(ctl.bankF2 ? baseNumF2 : baseNumF1)));

endmodule

// File: rtl/fsk_bank_sel.sv
module fsk_bank_sel
  import fsk_bank_pkg::*;
#(
  parameter int NUM_W     = 24,
  parameter int DEV_W     = 16,
  parameter int DEV_DEPTH = 8,
  localparam int IDX_W    = $clog2(DEV_DEPTH),
  localparam int TAB_W    = DEV_W * DEV_DEPTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bankSelReg,
  input  logic             trPinMode,
  input  logic             trPinAllow,
  input  logic             trPolarity,
  input  logic             fanoutEn,
  input  logic             trCtl,
  input  logic [1:0]       fskMode,
  input  logic [1:0]       fskLevel,
  input  logic [IDX_W-1:0] devSel,
  input  logic [IDX_W-1:0] symIn,
  input  logic [DEV_W-1:0] fastDev,
  input  logic             fskEnF1,
  input  logic             fskEnF2,
  input  logic [NUM_W-1:0] baseNumF1,
  input  logic [NUM_W-1:0] baseNumF2,
  input  logic [NUM_W-1:0] denF1,
  input  logic [NUM_W-1:0] denF2,
  input  logic [TAB_W-1:0] devTabF1,
  input  logic [TAB_W-1:0] devTabF2,
  output logic [NUM_W-1:0] numOut,
  output logic             bankOut,
  output logic             txEn,
  output logic             rxEn
);

  bankCtl_t         ctl;
  logic [IDX_W-1:0] devIndex;

  fsk_bank_ctrl #(.NUM_W(NUM_W), .DEV_DEPTH(DEV_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .bankSelReg(bankSelReg), .trPinMode(trPinMode),
    .trPinAllow(trPinAllow), .trPolarity(trPolarity), .fanoutEn(fanoutEn),
    .trCtl(trCtl), .fskMode(fskMode), .fskLevel(fskLevel), .devSel(devSel),
    .symIn(symIn), .fskEnF1(fskEnF1), .fskEnF2(fskEnF2), .denF1(denF1),
    .denF2(denF2), .ctl(ctl), .devIndex(devIndex)
  );

  fsk_bank_dp #(.NUM_W(NUM_W), .DEV_W(DEV_W), .DEV_DEPTH(DEV_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .devIndex(devIndex), .fastDev(fastDev),
    .baseNumF1(baseNumF1), .baseNumF2(baseNumF2), .devTabF1(devTabF1),
    .devTabF2(devTabF2), .numOut(numOut), .bankOut(bankOut), .txEn(txEn),
    .rxEn(rxEn)
  );

endmodule

// File: tb/fsk_bank_sel_test.sv
module fsk_bank_sel_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         bankSelReg = 0, trPinMode = 0, trPinAllow = 0, trPolarity = 0;
  logic         fanoutEn = 0, trCtl = 0, fskEnF1 = 0, fskEnF2 = 0;
  logic [1:0]   fskMode = 2'd3, fskLevel = 2'd0;
  logic [2:0]   devSel = 0, symIn = 0;
  logic [15:0]  fastDev = 16'h8000;
  logic [23:0]  baseNumF1 = 24'h123456, baseNumF2 = 24'h0000A0;
  logic [23:0]  denF1 = 0, denF2 = 0;
  logic [127:0] devTabF1, devTabF2;
  logic [23:0]  numOut;
  logic         bankOut, txEn, rxEn;

  int checks = 0, failures = 0, cycle = 0;
  bit finished = 0;

  typedef struct {
    int          due;
    logic [23:0] num;
    logic        bank, tx, rx;
    string       tag;
  } exp_t;
  exp_t q[$];

  fsk_bank_sel uut (.*);

  always #2.5 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  initial begin
    for (int k = 0; k < 8; k++) begin
      devTabF1[k*16 +: 16] = (k % 2 == 0) ? 16'(16'h0040 + k) : 16'(-(256 * k));
      devTabF2[k*16 +: 16] = (k < 4) ? 16'(16'h1000 + 16'h11 * k) : 16'(-(16 * k + 3));
    end
  end

  function automatic logic [15:0] tabWord(input logic f2, input int idx);
    return f2 ? devTabF2[idx*16 +: 16] : devTabF1[idx*16 +: 16];
  endfunction

  // Expected values from the requirements
  function automatic exp_t model(input string tag, input int due);
    exp_t e;
    logic f2, en, dz, apply;
    logic [15:0] d;
    int idx;
    f2 = (trPinMode && trPinAllow) ? !(trCtl ^ trPolarity) : bankSelReg;
    en = f2 ? fskEnF2 : fskEnF1;
    dz = f2 ? (denF2 == 0) : (denF1 == 0);
    apply = 0; d = 0;
    case (fskMode)
      2'd0: begin
        apply = en && dz && fskLevel != 0;
        idx = int'(symIn) & ((1 << fskLevel) - 1);
        d = tabWord(f2, idx);
      end
      2'd1: begin
        apply = en && dz && fskLevel != 0;
        d = tabWord(f2, int'(devSel));
      end
      2'd2: begin apply = en && dz; d = fastDev; end
      default: apply = 0;
    endcase
    e.due  = due;
    e.bank = f2;
    e.tx   = fanoutEn || !f2;
    e.rx   = fanoutEn || f2;
    e.num  = (f2 ? baseNumF2 : baseNumF1) + (apply ? {{8{d[15]}}, d} : 24'd0);
    e.tag  = tag;
    return e;
  endfunction

  task automatic checkOne(input exp_t e);
    checks++;
    if (numOut !== e.num || bankOut !== e.bank || txEn !== e.tx || rxEn !== e.rx) begin
      failures++;
      $display("FAIL %s: actual num=%h bank=%b tx=%b rx=%b expected num=%h bank=%b tx=%b rx=%b",
               e.tag, numOut, bankOut, txEn, rxEn, e.num, e.bank, e.tx, e.rx);
    end
  endtask

  // Driver: push expectation due after lat edges, then wait for it
  task automatic step(input int lat, input string tag);
    q.push_back(model(tag, cycle + lat));
    repeat (lat) @(negedge clk);
    #1;
  endtask

  // Monitor
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cycle) begin
        exp_t e;
        e = q.pop_front();
        if (e.due < cycle) begin
          checks++; failures++;
          $display("FAIL %s: actual check missed at cycle %0d expected cycle %0d", e.tag, cycle, e.due);
        end else checkOne(e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    r.due = 0; r.num = 0; r.bank = 0; r.tx = 0; r.rx = 0; r.tag = "R1 in reset";
    checkOne(r);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R2: register bank select
    bankSelReg = 0; step(1, "R2 F1");
    bankSelReg = 1; step(1, "R2 F2");
    // R3: pin ignored without the allow bit
    trPinMode = 1; trPinAllow = 0; trCtl = 1; step(3, "R3 pin ignored");
    // R4: pin mode, polarity 0
    trPinAllow = 1; step(1, "R4 high selects F1");
    q.push_back(model("R4 sync delay", cycle + 2));
    trCtl = 0; step(3, "R4 low selects F2");
    trPolarity = 1; step(1, "R4 polarity swap");
    // R5: fanout
    fanoutEn = 1; step(1, "R5 fanout");
    fanoutEn = 0; trPinMode = 0; trPinAllow = 0; trPolarity = 0; bankSelReg = 0;
    fskEnF1 = 1; fskMode = 2'd0; fskLevel = 2'd0; symIn = 3'd7;
    step(1, "R6 level 0 pin");
    fskLevel = 2'd1; step(1, "R7 two-level");
    fskLevel = 2'd2; step(1, "R7 four-level");
    fskLevel = 2'd3; symIn = 3'd6; step(1, "R7 eight-level");
    fskMode = 2'd1; devSel = 3'd5; step(1, "R8 R10 reg select negative");
    fskLevel = 2'd0; step(1, "R6 level 0 reg");
    fskMode = 2'd2; step(1, "R9 fast level 0");
    bankSelReg = 1; fskEnF2 = 1; fskMode = 2'd1; fskLevel = 2'd3; devSel = 3'd6;
    step(1, "R12 R10 F2 table wrap");
    denF2 = 24'd1000; step(1, "R11 nonzero den");
    denF2 = 0; fskEnF2 = 0; step(1, "R11 fsk disabled");
    fskEnF2 = 1; fskMode = 2'd3; step(1, "R11 mode off");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule